// File: doc/BRIEF.md
# Banked Address Decoder for a 64K Space with 128K Flash

This block sits between a CPU with a 16-bit address bus and its memories. It sorts each address into exactly one target: the low I/O register block, the on-chip RAM, the high I/O register block, the EEPROM, the page-select register, or flash. When the target is flash, it also forms a 17-bit physical flash address. The CPU space holds 64K, but the flash holds 128K in eight 16K pages. A 16K window shows whichever page the page-select register names. Three other ranges always show fixed pages: page 1 in the second quarter, page 3 in the top quarter (which holds the vectors), and page 0 in the part of the first quarter that nothing else claims. An address that no region claims raises an illegal-access flag in place of a select.

Decoding is combinational, from the address and the current page. The only state is the 3-bit page-select register. It sits at its own address inside the low I/O range and is written with a plain write strobe. It resets to page 2. A write is captured at the clock edge, so the access that follows it already sees the new page. The same register is read back through a data port that carries its value whenever its address is presented. No data stream passes through the block, so it has no valid/ready handshake. The address, write strobe and write data are plain control inputs, and the CPU is expected to hold them for the cycle it wants decoded.

Top module: `paged_addr_decoder`

## Requirements
- R1: Addresses 0x0000–0x007F, except the page-register address 0x0070, assert `sel_io_lo` only.
- R2: Addresses 0x0080–0x17FF assert `sel_ram` only. The first 128 RAM bytes (0x0080–0x00FF) therefore lie inside the 256-byte direct page.
- R3: Addresses 0x1800–0x18FF assert `sel_io_hi` only.
- R4: Addresses 0x1900–0x20FF assert `sel_eeprom` only.
- R5: Addresses 0x2100–0x27FF match no region. They assert `illegal` and no select.
- R6: Addresses 0x2800–0x3FFF assert `sel_flash`, with `flash_addr` = {3'd0, addr[13:0]}.
- R7: Addresses 0x4000–0x7FFF assert `sel_flash`, with `flash_addr` = {3'd1, addr[13:0]}, whatever the page register holds.
- R8: Addresses 0x8000–0xBFFF assert `sel_flash`, with `flash_addr` = {page, addr[13:0]}, where page is the current page-register value.
- R9: Addresses 0xC000–0xFFFF, including the vectors just below 0xFFFF, assert `sel_flash`, with `flash_addr` = {3'd3, addr[13:0]}, whatever the page register holds.
- R10: The page register resets to 2. When `cpu_wr` is high at a rising clock edge and the address is 0x0070, it loads `cpu_wdata`, and the next access decodes with the new page. A write to any other address leaves it unchanged.
- R11: Address 0x0070 asserts `sel_page_reg` only, and `rd_data` then equals the page register. At every other address `rd_data` is 0.
- R12: Exactly one of `sel_io_lo`, `sel_ram`, `sel_io_hi`, `sel_eeprom`, `sel_flash`, `sel_page_reg` and `illegal` is high at all times, and `flash_addr` is 0 whenever `sel_flash` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 3 | Write data for the page register |
| sel_io_lo | output | 1 | Low I/O block select |
| sel_ram | output | 1 | RAM select |
| sel_io_hi | output | 1 | High I/O block select |
| sel_eeprom | output | 1 | EEPROM select |
| sel_flash | output | 1 | Flash select |
| sel_page_reg | output | 1 | Page register select |
| illegal | output | 1 | No region matched |
| flash_addr | output | 17 | Physical flash address |
| rd_data | output | 3 | Page register read-back |

## Verification
The page register is the only state. If it holds a wrong value, the error shows on `rd_data` as soon as 0x0070 is presented, and in the upper three bits of `flash_addr` on any window access. Both show it in the same cycle, with no delay. The fixed regions must not depend on that state, so the bench changes the page and then probes the fixed regions, the window and the read-back. A lost or misrouted write shows one cycle after the write edge. The bench also probes both edges of every region, because a boundary off by one shows only as a wrong select at that one address.

// File: rtl/paged_addr_pkg.sv
package paged_addr_pkg;
  localparam int ADDR_W = 16;
  localparam int PAGE_W = 3;
  localparam int WIN_W  = 14;
  localparam int FADDR_W = PAGE_W + WIN_W;

  typedef enum logic [2:0] {
    TGT_NONE    = 3'd0,
    TGT_IO_LO   = 3'd1,
    TGT_RAM     = 3'd2,
    TGT_IO_HI   = 3'd3,
    TGT_EEPROM  = 3'd4,
    TGT_FLASH   = 3'd5,
    TGT_PAGEREG = 3'd6
  } target_e;

  localparam logic [ADDR_W-1:0] IO_LO_LAST  = 16'h007F;
  localparam logic [ADDR_W-1:0] RAM_LAST    = 16'h17FF;
  localparam logic [ADDR_W-1:0] IO_HI_LAST  = 16'h18FF;
  localparam logic [ADDR_W-1:0] EE_LAST     = 16'h20FF;
  localparam logic [ADDR_W-1:0] FLASH0_BASE = 16'h2800;
  localparam logic [1:0] QUAD_LOW    = 2'b00;
  localparam logic [1:0] QUAD_FIXED1 = 2'b01;
  localparam logic [1:0] QUAD_WINDOW = 2'b10;
  localparam logic [1:0] QUAD_FIXED3 = 2'b11;
  localparam logic [PAGE_W-1:0] PAGE_FIXED0 = 3'd0;
  localparam logic [PAGE_W-1:0] PAGE_FIXED1 = 3'd1;
  localparam logic [PAGE_W-1:0] PAGE_FIXED3 = 3'd3;
endpackage

// File: rtl/region_classifier.sv
module region_classifier
  import paged_addr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAGE_REG_ADDR = 16'h0070
) (
  input  logic [ADDR_W-1:0] addr,
  output target_e           target,
  output logic [1:0]        quad
);
  assign quad = addr[ADDR_W-1 -: 2];

  always_comb begin
    if (addr == PAGE_REG_ADDR)          target = TGT_PAGEREG;
    else if (addr <= IO_LO_LAST)        target = TGT_IO_LO;
    else if (addr <= RAM_LAST)          target = TGT_RAM;
    else if (addr <= IO_HI_LAST)        target = TGT_IO_HI;
    else if (addr <= EE_LAST)           target = TGT_EEPROM;
    else if (addr >= FLASH0_BASE)       target = TGT_FLASH;
    else                                target = TGT_NONE;
  end
endmodule

// File: rtl/page_select_reg.sv
module page_select_reg
  import paged_addr_pkg::*;
#(
  parameter logic [PAGE_W-1:0] RESET_PAGE = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page <= RESET_PAGE;
    else if (wr_en) page <= wdata;
  end
endmodule

// File: rtl/flash_addr_former.sv
module flash_addr_former
  import paged_addr_pkg::*;
(
  input  logic              is_flash,
  input  logic [1:0]        quad,
  input  logic [WIN_W-1:0]  offset,
  input  logic [PAGE_W-1:0] bank_page,
  output logic [FADDR_W-1:0] faddr
);
  logic [PAGE_W-1:0] eff_page;

  always_comb begin
    unique case (quad)
      QUAD_LOW:    eff_page = PAGE_FIXED0;
      QUAD_FIXED1: eff_page = PAGE_FIXED1;
      QUAD_WINDOW: eff_page = bank_page;
      QUAD_FIXED3: eff_page = PAGE_FIXED3;
      default:     eff_page = PAGE_FIXED0;
    endcase
  end

  assign faddr = is_flash ? {eff_page, offset} : '0;
endmodule

// File: rtl/paged_addr_decoder.sv
module paged_addr_decoder
  import paged_addr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAGE_REG_ADDR = 16'h0070,
  parameter logic [PAGE_W-1:0] RESET_PAGE    = 3'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_wr,
  input  logic [PAGE_W-1:0]  cpu_wdata,
  output logic               sel_io_lo,
  output logic               sel_ram,
  output logic               sel_io_hi,
  output logic               sel_eeprom,
  output logic               sel_flash,
  output logic               sel_page_reg,
  output logic               illegal,
  output logic [FADDR_W-1:0] flash_addr,
  output logic [PAGE_W-1:0]  rd_data
);
  target_e           target;
  logic [1:0]        quad;
  logic [PAGE_W-1:0] page_q;

  region_classifier #(.PAGE_REG_ADDR(PAGE_REG_ADDR)) u_cls (
    .addr   (cpu_addr),
    .target (target),
    .quad   (quad)
  );

  page_select_reg #(.RESET_PAGE(RESET_PAGE)) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cpu_wr && (target == TGT_PAGEREG)),
    .wdata (cpu_wdata),
    .page  (page_q)
  );

  flash_addr_former u_fa (
    .is_flash  (target == TGT_FLASH),
    .quad      (quad),
    .offset    (cpu_addr[WIN_W-1:0]),
    .bank_page (page_q),
    .faddr     (flash_addr)
  );

  assign sel_io_lo    = (target == TGT_IO_LO);
  assign sel_ram      = (target == TGT_RAM);
  assign sel_io_hi    = (target == TGT_IO_HI);
  assign sel_eeprom   = (target == TGT_EEPROM);
  assign sel_flash    = (target == TGT_FLASH);
  assign sel_page_reg = (target == TGT_PAGEREG);
  assign illegal      = (target == TGT_NONE);
  assign rd_data      = sel_page_reg ? page_q : '0;
endmodule

// File: rtl/paged_addr_decoder_chk.sv
module paged_addr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic [2:0]  cpu_wdata,
  input logic        sel_io_lo,
  input logic        sel_ram,
  input logic        sel_io_hi,
  input logic        sel_eeprom,
  input logic        sel_flash,
  input logic        sel_page_reg,
  input logic        illegal,
  input logic [16:0] flash_addr,
  input logic [2:0]  rd_data,
  input logic [2:0]  page_q
);
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_io_lo, sel_ram, sel_io_hi, sel_eeprom, sel_flash, sel_page_reg, illegal}) == 1); // R12
  AST_FADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_flash |-> flash_addr == 17'd0); // R12
  AST_FIXED1_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:14] == 2'b01 |-> sel_flash && flash_addr[16:14] == 3'd1); // R7
  AST_WINDOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:14] == 2'b10 |-> sel_flash && flash_addr[16:14] == page_q); // R8
  AST_FIXED3_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[15:14] == 2'b11 |-> sel_flash && flash_addr[16:14] == 3'd3); // R9
  AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && sel_page_reg |=> page_q == $past(cpu_wdata)); // R10
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && sel_page_reg) |=> $stable(page_q)); // R10
  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    sel_page_reg |-> rd_data == page_q); // R11
endmodule

bind paged_addr_decoder paged_addr_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .sel_io_lo(sel_io_lo), .sel_ram(sel_ram),
  .sel_io_hi(sel_io_hi), .sel_eeprom(sel_eeprom), .sel_flash(sel_flash),
  .sel_page_reg(sel_page_reg), .illegal(illegal), .flash_addr(flash_addr),
  .rd_data(rd_data), .page_q(page_q)
);

// File: tb/paged_addr_decoder_tb_top.sv
module paged_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        cpu_wr = 1'b0;
  logic [2:0]  cpu_wdata = 3'd0;
  logic sel_io_lo, sel_ram, sel_io_hi, sel_eeprom, sel_flash, sel_page_reg, illegal;
  logic [16:0] flash_addr;
  logic [2:0]  rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [2:0] exp_page;
  bit done = 1'b0;

  always #5 clk = ~clk;

  paged_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .sel_io_lo(sel_io_lo), .sel_ram(sel_ram),
    .sel_io_hi(sel_io_hi), .sel_eeprom(sel_eeprom), .sel_flash(sel_flash),
    .sel_page_reg(sel_page_reg), .illegal(illegal), .flash_addr(flash_addr),
    .rd_data(rd_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // select vector order: {page_reg, flash, eeprom, io_hi, ram, io_lo, illegal}
  function automatic logic [6:0] exp_sel(logic [15:0] a);
    if (a == 16'h0070)      return 7'b1000000;
    else if (a <= 16'h007F) return 7'b0000010;
    else if (a <= 16'h17FF) return 7'b0000100;
    else if (a <= 16'h18FF) return 7'b0001000;
    else if (a <= 16'h20FF) return 7'b0010000;
    else if (a <  16'h2800) return 7'b0000001;
    else                    return 7'b0100000;
  endfunction

  function automatic logic [16:0] exp_fa(logic [15:0] a, logic [2:0] pg);
    if (a < 16'h2800)      return 17'd0;
    else if (a < 16'h4000) return {3'd0, a[13:0]};
    else if (a < 16'h8000) return {3'd1, a[13:0]};
    else if (a < 16'hC000) return {pg, a[13:0]};
    else                   return {3'd3, a[13:0]};
  endfunction

  task automatic probe(string req, logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    #1;
    chk(req, {25'd0, sel_page_reg, sel_flash, sel_eeprom, sel_io_hi, sel_ram, sel_io_lo, illegal},
        {25'd0, exp_sel(a)});
    chk(req, {15'd0, flash_addr}, {15'd0, exp_fa(a, exp_page)});
    chk(req, {29'd0, rd_data}, (a == 16'h0070) ? {29'd0, exp_page} : 32'd0);
  endtask

  task automatic write(logic [15:0] a, logic [2:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
    if (a == 16'h0070) exp_page = d;
  endtask

  task automatic t_reset;
    exp_page = 3'd2;
    probe("R10", 16'h0070);
    probe("R8", 16'h8000);
  endtask

  task automatic t_low_regions;
    probe("R1", 16'h0000); probe("R1", 16'h006F); probe("R1", 16'h0071); probe("R1", 16'h007F);
    probe("R2", 16'h0080); probe("R2", 16'h00FF); probe("R2", 16'h17FF);
    probe("R3", 16'h1800); probe("R3", 16'h18FF);
    probe("R4", 16'h1900); probe("R4", 16'h20FF);
    probe("R5", 16'h2100); probe("R5", 16'h27FF);
    probe("R6", 16'h2800); probe("R6", 16'h3FFF);
  endtask

  task automatic t_fixed_pages;
    probe("R7", 16'h4000); probe("R7", 16'h7FFF);
    probe("R9", 16'hC000); probe("R9", 16'hFFFE); probe("R9", 16'hFFFF);
  endtask

  task automatic t_window_writes;
    for (int p = 0; p < 8; p++) begin
      write(16'h0070, 3'(p));
      probe("R8", 16'h8123);
      probe("R8", 16'hBFFF);
      probe("R11", 16'h0070);
      probe("R7", 16'h5555);
      probe("R9", 16'hFFFC);
      probe("R6", 16'h3000);
    end
  endtask

  task automatic t_write_elsewhere;
    write(16'h0070, 3'd5);
    write(16'h0071, 3'd1);
    write(16'h8000, 3'd6);
    write(16'h1800, 3'd0);
    probe("R10", 16'h0070);
    probe("R10", 16'h9000);
  endtask

  task automatic t_readback_zero;
    probe("R11", 16'h0000);
    probe("R11", 16'hFFFF);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 4096; i++) probe("R12", 16'(i * 16 + (i % 16)));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    exp_page = 3'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low_regions();
    t_fixed_pages();
    t_window_writes();
    t_write_elsewhere();
    t_readback_zero();
    t_sweep();
    done = 1'b1;
    summary();
  end
endmodule